// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds eight 80-bit floating-point registers that software reaches through a rotating stack rather than by fixed index. A 3-bit stack-top pointer names the physical register that currently acts as the top of the stack, st(0). Every other logical slot st(i) lies i places further around the ring. The block keeps one occupancy tag per physical register. It treats each data word as an opaque 80-bit value and does no arithmetic on it.

One operation may be presented per clock. The operations are: push a word, pop the top word while reading it, rotate the pointer up or down, release any logical slot, and write or read any logical slot. A push onto an occupied register is an overflow. A read of an empty register is an underflow. Either one sets a sticky fault flag. On an overflow, a mask input chooses between aborting the push and substituting a default quiet-NaN word.

Top module: `fp_stack_regfile`

## Requirements
- R1: After reset the stack-top pointer is 0, every register is empty, and the fault flag is clear.
- R2: Logical slot st(i) addresses physical register (top + i) mod 8 for write, read and release.
- R3: A push onto an empty register moves the pointer to (top - 1) mod 8, stores wr_data there, and marks that register occupied.
- R4: A push onto an occupied register with fault_mask=1 sets the fault flag and still moves the pointer. It stores the default NaN and leaves the register occupied. The default NaN has bit 79 = 1, bits 78:64 = 0x7FFF and bits 63:0 = 0xC000_0000_0000_0000.
- R5: A push onto an occupied register with fault_mask=0 sets the fault flag and changes neither the pointer nor any data or tag.
- R6: A pop presents the old st(0) on rd_data in the same cycle. It then marks that register empty and moves the pointer to (top + 1) mod 8.
- R7: A rotate-up adds 1 to the pointer and a rotate-down subtracts 1, both mod 8, with no change to data or tags.
- R8: A release marks st(i) empty and leaves the pointer unchanged.
- R9: A read or pop that addresses an empty register raises rd_underflow combinationally, returns the default NaN, and sets the fault flag at the next edge.
- R10: The fault flag stays set until fault_clr is high at a clock edge. A new fault in that same cycle wins over the clear.
- R11: op_code encodings are 0 none, 1 push, 2 pop, 3 rotate-up, 4 rotate-down, 5 release, 6 write, 7 read. With op_valid low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation encoding (R11) |
| op_idx | input | 3 | Logical slot i for release, write and read |
| wr_data | input | 80 | Word for push and write |
| fault_mask | input | 1 | 1: masked overflow stores NaN; 0: overflow aborts the push |
| fault_clr | input | 1 | Clears the sticky fault flag |
| rd_data | output | 80 | Word of the addressed slot, or NaN if that slot is empty |
| rd_underflow | output | 1 | A read or pop hits an empty register this cycle |
| top_ptr | output | 3 | Current stack-top pointer |
| fault_flag | output | 1 | Sticky stack-fault flag |

## Verification
The interesting collision is a fault clear and a new overflow or underflow landing on the same edge. The bench forces this with directed cycles: it holds fault_clr high during a read of an empty slot and during a push onto a full ring, and it expects the flag to end up set. Random traffic also raises fault_clr now and then while the ring is often full or empty, so the two events meet again at varied pointer values. Each outcome is judged against a reference model that clears first and then sets.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    localparam int WORD_W = 80;

    typedef logic [WORD_W-1:0] word_t;

    // sign 1, exponent all ones, significand with top two bits set
    localparam word_t QNAN_DEFAULT = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4,
        OP_FREE  = 3'd5,
        OP_WRITE = 3'd6,
        OP_READ  = 3'd7
    } stk_op_e;

endpackage

// File: rtl/fpstk_slot_map.sv
// Ring address adder: physical = (base + offset) mod 2**PTR_W
module fpstk_slot_map #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] base_i,
    input  logic [PTR_W-1:0] offset_i,
    output logic [PTR_W-1:0] phys_o
);
    assign phys_o = base_i + offset_i;
endmodule

// File: rtl/fpstk_data_bank.sv
module fpstk_data_bank
    import fpstk_pkg::*;
#(
    parameter int N_REGS = 8,
    localparam int PTR_W = $clog2(N_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [PTR_W-1:0]         waddr_i,
    input  word_t                    wdata_i,
    output word_t [N_REGS-1:0]       bank_o
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_entry
        word_t word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (we_i && (waddr_i == PTR_W'(g))) begin
                word_d = wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign bank_o[g] = word_q;
    end
endmodule

// File: rtl/fpstk_read_port.sv
module fpstk_read_port
    import fpstk_pkg::*;
#(
    parameter int N_REGS = 8,
    localparam int PTR_W = $clog2(N_REGS)
) (
    input  word_t [N_REGS-1:0] bank_i,
    input  logic  [N_REGS-1:0] busy_i,
    input  logic  [PTR_W-1:0]  sel_i,
    output word_t              data_o,
    output logic               empty_o
);
    always_comb begin
        empty_o = !busy_i[sel_i];
        data_o  = empty_o ? QNAN_DEFAULT : bank_i[sel_i];
    end
endmodule

// File: rtl/fp_stack_regfile.sv
// Eight-entry register file addressed as a rotating stack.
// N_REGS must be a power of two so the pointer wraps naturally.
module fp_stack_regfile
    import fpstk_pkg::*;
#(
    parameter int N_REGS = 8,
    localparam int PTR_W = $clog2(N_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [2:0]           op_code,
    input  logic [PTR_W-1:0]     op_idx,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 fault_mask,
    input  logic                 fault_clr,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_underflow,
    output logic [PTR_W-1:0]     top_ptr,
    output logic                 fault_flag
);
    typedef struct packed {
        logic [PTR_W-1:0]  top;
        logic [N_REGS-1:0] busy;
        logic              fault;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    stk_op_e op;
    assign op = stk_op_e'(op_code);

    logic [PTR_W-1:0] phys_op, phys_push, rd_sel;
    logic             bank_we;
    logic [PTR_W-1:0] bank_waddr;
    word_t            bank_wdata;
    word_t [N_REGS-1:0] bank;
    word_t            port_data;
    logic             port_empty;
    logic             overflow;

    fpstk_slot_map #(.PTR_W(PTR_W)) u_map_op (
        .base_i   (ctl_q.top),
        .offset_i (op_idx),
        .phys_o   (phys_op)
    );

    // offset of all ones is a decrement by one around the ring
    fpstk_slot_map #(.PTR_W(PTR_W)) u_map_push (
        .base_i   (ctl_q.top),
        .offset_i ({PTR_W{1'b1}}),
        .phys_o   (phys_push)
    );

    assign rd_sel = (op == OP_POP) ? ctl_q.top : phys_op;

    fpstk_read_port #(.N_REGS(N_REGS)) u_rd (
        .bank_i  (bank),
        .busy_i  (ctl_q.busy),
        .sel_i   (rd_sel),
        .data_o  (port_data),
        .empty_o (port_empty)
    );

    fpstk_data_bank #(.N_REGS(N_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bank_we),
        .waddr_i (bank_waddr),
        .wdata_i (bank_wdata),
        .bank_o  (bank)
    );

    assign rd_underflow = op_valid && ((op == OP_POP) || (op == OP_READ)) && port_empty;
    assign rd_data      = port_data;

    always_comb begin
        ctl_d      = ctl_q;
        bank_we    = 1'b0;
        bank_waddr = ctl_q.top;
        bank_wdata = wr_data;
        overflow   = 1'b0;

        if (op_valid) begin
            unique case (op)
                OP_PUSH: begin
                    if (ctl_q.busy[phys_push]) begin
                        overflow = 1'b1;
                        if (fault_mask) begin
                            ctl_d.top             = phys_push;
                            ctl_d.busy[phys_push] = 1'b1;
                            bank_we               = 1'b1;
                            bank_waddr            = phys_push;
                            bank_wdata            = QNAN_DEFAULT;
                        end
                    end else begin
                        ctl_d.top             = phys_push;
                        ctl_d.busy[phys_push] = 1'b1;
                        bank_we               = 1'b1;
                        bank_waddr            = phys_push;
                    end
                end
                OP_POP: begin
                    ctl_d.busy[ctl_q.top] = 1'b0;
                    ctl_d.top             = ctl_q.top + 1'b1;
                end
                OP_INC:  ctl_d.top = ctl_q.top + 1'b1;
                OP_DEC:  ctl_d.top = ctl_q.top - 1'b1;
                OP_FREE: ctl_d.busy[phys_op] = 1'b0;
                OP_WRITE: begin
                    ctl_d.busy[phys_op] = 1'b1;
                    bank_we             = 1'b1;
                    bank_waddr          = phys_op;
                end
                default: ;
            endcase
        end

        // clear first, then a fresh fault takes priority
        if (fault_clr) begin
            ctl_d.fault = 1'b0;
        end
        if (overflow || rd_underflow) begin
            ctl_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{top: '0, busy: '0, fault: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign top_ptr    = ctl_q.top;
    assign fault_flag = ctl_q.fault;

endmodule

// File: rtl/fpstk_checker.sv
module fpstk_checker
    import fpstk_pkg::*;
#(
    parameter int N_REGS = 8,
    localparam int PTR_W = $clog2(N_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic              fault_clr,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_underflow,
    input logic [PTR_W-1:0]  top_ptr,
    input logic              fault_flag
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (top_ptr == '0 && !fault_flag)); // R1

    AST_INC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_INC) |=> (top_ptr == PTR_W'($past(top_ptr) + 1'b1))); // R7

    AST_DEC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_DEC) |=> (top_ptr == PTR_W'($past(top_ptr) - 1'b1))); // R7

    AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_POP) |=> (top_ptr == PTR_W'($past(top_ptr) + 1'b1))); // R6

    AST_FREE_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_FREE) |=> $stable(top_ptr)); // R8

    AST_UNDERFLOW_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_underflow |-> (rd_data == QNAN_DEFAULT)); // R9

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_underflow |=> fault_flag); // R9

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> fault_flag); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(top_ptr)); // R11
endmodule

bind fp_stack_regfile fpstk_checker #(.N_REGS(N_REGS)) u_fpstk_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .fault_clr    (fault_clr),
    .rd_data      (rd_data),
    .rd_underflow (rd_underflow),
    .top_ptr      (top_ptr),
    .fault_flag   (fault_flag)
);

// File: tb/fp_stack_regfile_bench.sv
module fp_stack_regfile_bench;
    localparam logic [79:0] NAN = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
    localparam logic [2:0] C_NOP = 0, C_PUSH = 1, C_POP = 2, C_INC = 3,
                           C_DEC = 4, C_FREE = 5, C_WRITE = 6, C_READ = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  op_idx = '0;
    logic [79:0] wr_data = '0;
    logic        fault_mask = 1'b1;
    logic        fault_clr = 1'b0;
    logic [79:0] rd_data;
    logic        rd_underflow;
    logic [2:0]  top_ptr;
    logic        fault_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [79:0] m_data [8];
    bit          m_busy [8];
    int          m_top;
    bit          m_fault;

    always #2 clk = ~clk;

    fp_stack_regfile u_fp_stack_regfile (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_idx(op_idx), .wr_data(wr_data), .fault_mask(fault_mask),
        .fault_clr(fault_clr), .rd_data(rd_data), .rd_underflow(rd_underflow),
        .top_ptr(top_ptr), .fault_flag(fault_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int wrap(input int v);
        return ((v % 8) + 8) % 8;
    endfunction

    task automatic check_state(input string req);
        chk(top_ptr == 3'(m_top), req, "top_ptr", 80'(top_ptr), 80'(m_top));
        chk(fault_flag == m_fault, req, "fault_flag", 80'(fault_flag), 80'(m_fault));
    endtask

    task automatic do_op(input logic [2:0] op, input logic [2:0] idx,
                         input logic [79:0] d, input bit mask, input bit clr,
                         input string req);
        int slot;
        bit unf;
        bit ovf;
        logic [79:0] exp_rd;
        unf = 0;
        ovf = 0;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_idx = idx; wr_data = d;
        fault_mask = mask; fault_clr = clr;
        #1;
        if (op == C_POP || op == C_READ) begin
            slot = (op == C_POP) ? m_top : wrap(m_top + idx);
            unf = !m_busy[slot];
            exp_rd = unf ? NAN : m_data[slot];
            chk(rd_underflow == unf, req, "rd_underflow", 80'(rd_underflow), 80'(unf));
            chk(rd_data == exp_rd, req, "rd_data", rd_data, exp_rd);
        end
        case (op)
            C_PUSH: begin
                slot = wrap(m_top - 1);
                if (m_busy[slot]) begin
                    ovf = 1;
                    if (mask) begin
                        m_top = slot; m_busy[slot] = 1; m_data[slot] = NAN;
                    end
                end else begin
                    m_top = slot; m_busy[slot] = 1; m_data[slot] = d;
                end
            end
            C_POP: begin
                m_busy[m_top] = 0; m_top = wrap(m_top + 1);
            end
            C_INC: m_top = wrap(m_top + 1);
            C_DEC: m_top = wrap(m_top - 1);
            C_FREE: m_busy[wrap(m_top + idx)] = 0;
            C_WRITE: begin
                m_busy[wrap(m_top + idx)] = 1; m_data[wrap(m_top + idx)] = d;
            end
            default: ;
        endcase
        if (clr) m_fault = 0;
        if (ovf || unf) m_fault = 1;
        @(posedge clk);
        #1;
        op_valid = 1'b0; fault_clr = 1'b0;
        check_state(req);
    endtask

    function automatic logic [79:0] rnd80();
        return {16'($urandom), $urandom, $urandom};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin m_data[i] = '0; m_busy[i] = 0; end
        m_top = 0; m_fault = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R1: an empty stack, read of st(0) underflows; clear in the same cycle loses (R10)
        do_op(C_READ, 3'd0, '0, 1, 1, "R1/R9/R10");
        do_op(C_NOP, 3'd0, '0, 1, 1, "R10");

        // R3: fill the ring, last-in first-out order
        for (int i = 0; i < 8; i++) do_op(C_PUSH, 3'd0, 80'(i + 100), 1, 0, "R3");
        for (int i = 0; i < 8; i++) do_op(C_READ, 3'(i), '0, 1, 0, "R2");
        // R5: unmasked overflow aborts
        do_op(C_PUSH, 3'd0, 80'hABC, 0, 0, "R5");
        do_op(C_READ, 3'd0, '0, 1, 0, "R5");
        // R4: masked overflow writes NaN, with a clear in the same cycle (R10)
        do_op(C_PUSH, 3'd0, 80'hDEF, 1, 1, "R4/R10");
        do_op(C_READ, 3'd0, '0, 1, 0, "R4");
        // R11: idle cycle changes nothing
        @(negedge clk); op_valid = 1'b0; op_code = C_POP;
        @(posedge clk); #1 check_state("R11");
        // R7: rotations keep data
        do_op(C_INC, 3'd0, '0, 1, 0, "R7");
        do_op(C_READ, 3'd7, '0, 1, 0, "R7");
        do_op(C_DEC, 3'd0, '0, 1, 0, "R7");
        do_op(C_DEC, 3'd0, '0, 1, 0, "R7");
        do_op(C_READ, 3'd1, '0, 1, 0, "R7");
        // R8: release without moving the pointer
        do_op(C_FREE, 3'd3, '0, 1, 1, "R8");
        do_op(C_READ, 3'd3, '0, 1, 0, "R8/R9");
        // R6: pop everything, including empty slots
        for (int i = 0; i < 9; i++) do_op(C_POP, 3'd0, '0, 1, 0, "R6");
        // R2: write into arbitrary slots
        do_op(C_WRITE, 3'd5, 80'h1234_5678, 1, 1, "R2");
        do_op(C_READ, 3'd5, '0, 1, 0, "R2");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] op;
            op = 3'($urandom % 8);
            do_op(op, 3'($urandom % 8), rnd80(), ($urandom % 4) != 0,
                  ($urandom % 16) == 0, "R2/R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule